// File: doc/BRIEF.md
# Fractional Baud Divisor Search Engine

This block finds the register settings that bring a serial port's baud generator as close as possible to a requested rate. It is given the frequency of the clock that feeds the port and the wanted baud rate. It then walks every pairing of a fractional multiplier (1 to 15) with an additive term (0 to 15). For each pair it derives a rounded 16-bit integer divisor. It keeps the pairing whose resulting rate lies nearest the target.

The work is done by one shared iterative restoring divider. A pulse on `start_i` begins the search. Each candidate costs the same fixed number of cycles. When the search ends, `done_o` rises and stays high together with three byte-wide results: the high divisor byte, the low divisor byte, and a fractional byte. A loader can copy these bytes straight into the port's registers. If no candidate comes close enough, `success_o` stays low and the bytes hold a plain integer-only setting instead.

Top module: `baud_frac_search`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `success_o` are low and all three result bytes are zero.
- R2: The input clock is first divided by 16 (shift right by 4), giving P. For multiplier m and additive term a, the scaled clock is T = (m*P)/(m+a) in integer arithmetic. The divisor D is T/baud, plus one when the remainder T%baud is strictly greater than baud/2. A candidate counts only when 2 < D < 65536. Its error is |T/D - baud|. It replaces the stored best only when that error is strictly smaller. The best starts with error 100000, m = 1, a = 0 and divisor 0. On success, `div_hi_o` = D[15:8], `div_lo_o` = D[7:0], and `frac_o` = {m[3:0], a[3:0]} (multiplier in bits 7:4, additive term in bits 3:0).
- R3: Candidates are visited with m from 1 to 15 in the outer loop and a from 0 to 15 in the inner loop. The sweep stops right after a candidate with zero error is stored.
- R4: Each visited candidate takes 3*(CLK_W+2) cycles, and the tolerance step takes a further CLK_W+2 cycles. When n candidates are visited, `done_o` is first high (3n+1)*(CLK_W+2) cycles after the clock edge that accepts start on success, and (3n+2)*(CLK_W+2) cycles after that edge on failure.
- R5: `success_o` is high only when the best error is strictly below baud/30 (integer division).
- R6: On failure, the divisor bytes are bits [15:8] and [7:0] of P/baud, and `frac_o` is 8'h10.
- R7: A baud of zero ends the run at the accepting edge itself. `done_o` is high and `success_o` is low in the following cycle, both divisor bytes are zero, and `frac_o` is 8'h10.
- R8: A start pulse while `busy_o` is high is ignored. The run in progress completes with the inputs captured at its own start, and takes its own cycle count.
- R9: From the cycle `done_o` rises until the next accepted start, `done_o`, `success_o` and the three result bytes hold their values, even when the clock and baud inputs change.
- R10: `busy_o` is high from the accepting edge until the result is posted, and `busy_o` and `done_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search; accepted only when not busy |
| uart_clk_i | input | CLK_W | Frequency of the port's input clock, in Hz |
| baud_i | input | CLK_W | Target baud rate |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Results valid; held until the next accepted start |
| success_o | output | 1 | A candidate met the tolerance |
| div_hi_o | output | 8 | Integer divisor, upper byte |
| div_lo_o | output | 8 | Integer divisor, lower byte |
| frac_o | output | 8 | Multiplier in bits 7:4, additive term in bits 3:0 |

## Verification
The bench builds the block with CLK_W = 24 and leaves every other parameter at its default. Each division then takes 24 steps, so a full sweep of all 240 pairs costs about 18,700 cycles. This lets several complete sweeps run: the failure path, the busy-start case and generic rates. Clock values up to about 16.7 MHz reach divisors inside the 3..65535 window, cases with an exact rate at the first pair, and rates such as 400 kbaud at which no pair qualifies. The 100000 starting error and the baud/30 tolerance keep their default values, so the success decision is exercised exactly as it would be in the full-width build.

// File: rtl/baud_srch_pkg.sv
package baud_srch_pkg;

  localparam int FLD_W = 4;
  localparam logic [7:0] INT_ONLY_FRAC = 8'h10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAIR,
    ST_QUOT,
    ST_RATE,
    ST_TOL,
    ST_FALL
  } srch_st_e;

  function automatic logic [7:0] pack_frac(input logic [FLD_W-1:0] mul,
                                           input logic [FLD_W-1:0] add);
    return {mul, add};
  endfunction

endpackage

// File: rtl/baud_srch_divider.sv
module baud_srch_divider #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         fin_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  quo_q, rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;

  // one restoring step: shift in the next dividend bit, try to subtract
  logic [W:0] shifted, diff;
  logic       fits;
  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign fits    = shifted >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else if (go_i) begin
      quo_q <= num_i;
      rem_q <= '0;
      den_q <= den_i;
      cnt_q <= CW'(W - 1);
      run_q <= 1'b1;
      fin_q <= 1'b0;
    end else if (run_q) begin
      rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      if (cnt_q == '0) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign fin_o = fin_q;
  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/baud_srch_best.sv
module baud_srch_best
  import baud_srch_pkg::*;
#(
  parameter int W        = 32,
  parameter int DIV_W    = 16,
  parameter int ERR_INIT = 100000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             offer_i,
  input  logic [W-1:0]     err_i,
  input  logic [FLD_W-1:0] mul_i,
  input  logic [FLD_W-1:0] add_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             take_o,
  output logic [W-1:0]     best_err_o,
  output logic [FLD_W-1:0] best_mul_o,
  output logic [FLD_W-1:0] best_add_o,
  output logic [DIV_W-1:0] best_div_o
);
  logic [W-1:0]     err_q;
  logic [FLD_W-1:0] mul_q, add_q;
  logic [DIV_W-1:0] div_q;

  // strictly smaller error wins; ties keep the earlier pair
  assign take_o = offer_i && (err_i < err_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= W'(ERR_INIT);
      mul_q <= FLD_W'(1);
      add_q <= '0;
      div_q <= '0;
    end else if (clear_i) begin
      err_q <= W'(ERR_INIT);
      mul_q <= FLD_W'(1);
      add_q <= '0;
      div_q <= '0;
    end else if (take_o) begin
      err_q <= err_i;
      mul_q <= mul_i;
      add_q <= add_i;
      div_q <= div_i;
    end
  end

  assign best_err_o = err_q;
  assign best_mul_o = mul_q;
  assign best_add_o = add_q;
  assign best_div_o = div_q;
endmodule

// File: rtl/baud_frac_search.sv
module baud_frac_search
  import baud_srch_pkg::*;
#(
  parameter int CLK_W    = 32,
  parameter int DIV_W    = 16,
  parameter int MUL_MAX  = 15,
  parameter int ADD_MAX  = 15,
  parameter int ERR_INIT = 100000,
  parameter int TOL_DEN  = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CLK_W-1:0] uart_clk_i,
  input  logic [CLK_W-1:0] baud_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             success_o,
  output logic [7:0]       div_hi_o,
  output logic [7:0]       div_lo_o,
  output logic [7:0]       frac_o
);
  localparam int W = CLK_W;
  localparam logic [W:0]       DIV_LIM = (W+1)'(1) << DIV_W;
  localparam logic [FLD_W-1:0] M_LAST  = FLD_W'(MUL_MAX);
  localparam logic [FLD_W-1:0] A_LAST  = FLD_W'(ADD_MAX);

  // ---- arithmetic helpers ----
  function automatic logic round_bump(input logic [W-1:0] rem, input logic [W-1:0] den);
    return rem > (den >> 1);
  endfunction

  function automatic logic in_window(input logic [W:0] d);
    return (d > (W+1)'(2)) && (d < DIV_LIM);
  endfunction

  function automatic logic [W-1:0] abs_gap(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  function automatic logic [W-1:0] scaled_num(input logic [FLD_W-1:0] m, input logic [W-1:0] pc);
    return W'(m) * pc;
  endfunction

  // ---- state ----
  srch_st_e         st_q;
  logic [W-1:0]     pclk_q, baud_q, temp_q;
  logic [DIV_W-1:0] cand_q;
  logic             win_q;
  logic [FLD_W-1:0] m_q, a_q;
  logic             busy_q, done_q, ok_q;
  logic [7:0]       hi_q, lo_q, frac_q;

  logic             dv_go_q;
  logic [W-1:0]     dv_num_q, dv_den_q;
  logic             dv_fin;
  logic [W-1:0]     dv_quo, dv_rem;

  // ---- named events ----
  logic             accept;
  logic             offer;
  logic             take;
  logic [W-1:0]     cand_err;
  logic             zero_hit;
  logic             last_pair;
  logic             sweep_end;
  logic [W:0]       cand_next;
  logic [FLD_W-1:0] nxt_m, nxt_a;
  logic [W-1:0]     best_err;
  logic [FLD_W-1:0] best_m, best_a;
  logic [DIV_W-1:0] best_div;

  assign accept    = start_i && (st_q == ST_IDLE);
  assign offer     = (st_q == ST_RATE) && dv_fin && win_q;
  assign cand_err  = abs_gap(dv_quo, baud_q);
  assign zero_hit  = take && (cand_err == '0);
  assign last_pair = (m_q == M_LAST) && (a_q == A_LAST);
  assign sweep_end = zero_hit || last_pair;
  assign cand_next = {1'b0, dv_quo} + (W+1)'(round_bump(dv_rem, baud_q));
  assign nxt_a     = (a_q == A_LAST) ? '0 : a_q + 1'b1;
  assign nxt_m     = (a_q == A_LAST) ? m_q + 1'b1 : m_q;

  baud_srch_divider #(.W(W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (dv_go_q),
    .num_i  (dv_num_q),
    .den_i  (dv_den_q),
    .fin_o  (dv_fin),
    .quo_o  (dv_quo),
    .rem_o  (dv_rem)
  );

  baud_srch_best #(.W(W), .DIV_W(DIV_W), .ERR_INIT(ERR_INIT)) u_best (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .offer_i    (offer),
    .err_i      (cand_err),
    .mul_i      (m_q),
    .add_i      (a_q),
    .div_i      (cand_q),
    .take_o     (take),
    .best_err_o (best_err),
    .best_mul_o (best_m),
    .best_add_o (best_a),
    .best_div_o (best_div)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pclk_q   <= '0;
      baud_q   <= '0;
      temp_q   <= '0;
      cand_q   <= '0;
      win_q    <= 1'b0;
      m_q      <= FLD_W'(1);
      a_q      <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      frac_q   <= '0;
      dv_go_q  <= 1'b0;
      dv_num_q <= '0;
      dv_den_q <= '0;
    end else begin
      dv_go_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          pclk_q <= uart_clk_i >> 4;
          baud_q <= baud_i;
          ok_q   <= 1'b0;
          m_q    <= FLD_W'(1);
          a_q    <= '0;
          if (baud_i == '0) begin
            done_q <= 1'b1;
            hi_q   <= '0;
            lo_q   <= '0;
            frac_q <= INT_ONLY_FRAC;
          end else begin
            done_q   <= 1'b0;
            busy_q   <= 1'b1;
            dv_go_q  <= 1'b1;
            dv_num_q <= scaled_num(FLD_W'(1), uart_clk_i >> 4);
            dv_den_q <= W'(1);
            st_q     <= ST_PAIR;
          end
        end
        ST_PAIR: if (dv_fin) begin
          temp_q   <= dv_quo;
          dv_go_q  <= 1'b1;
          dv_num_q <= dv_quo;
          dv_den_q <= baud_q;
          st_q     <= ST_QUOT;
        end
        ST_QUOT: if (dv_fin) begin
          cand_q   <= cand_next[DIV_W-1:0];
          win_q    <= in_window(cand_next);
          dv_go_q  <= 1'b1;
          dv_num_q <= temp_q;
          dv_den_q <= cand_next[W-1:0];
          st_q     <= ST_RATE;
        end
        ST_RATE: if (dv_fin) begin
          dv_go_q <= 1'b1;
          if (sweep_end) begin
            dv_num_q <= baud_q;
            dv_den_q <= W'(TOL_DEN);
            st_q     <= ST_TOL;
          end else begin
            m_q      <= nxt_m;
            a_q      <= nxt_a;
            dv_num_q <= scaled_num(nxt_m, pclk_q);
            dv_den_q <= W'(nxt_m) + W'(nxt_a);
            st_q     <= ST_PAIR;
          end
        end
        ST_TOL: if (dv_fin) begin
          if (best_err < dv_quo) begin
            ok_q   <= 1'b1;
            done_q <= 1'b1;
            busy_q <= 1'b0;
            hi_q   <= best_div[15:8];
            lo_q   <= best_div[7:0];
            frac_q <= pack_frac(best_m, best_a);
            st_q   <= ST_IDLE;
          end else begin
            dv_go_q  <= 1'b1;
            dv_num_q <= pclk_q;
            dv_den_q <= baud_q;
            st_q     <= ST_FALL;
          end
        end
        ST_FALL: if (dv_fin) begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
          hi_q   <= dv_quo[15:8];
          lo_q   <= dv_quo[7:0];
          frac_q <= INT_ONLY_FRAC;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign success_o = ok_q;
  assign div_hi_o  = hi_q;
  assign div_lo_o  = lo_q;
  assign frac_o    = frac_q;
endmodule

// File: rtl/baud_frac_search_chk.sv
module baud_frac_search_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] baud_i,
  input logic         accept_i,
  input logic [W-1:0] baud_q_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         success_o,
  input logic [7:0]   div_hi_o,
  input logic [7:0]   div_lo_o,
  input logic [7:0]   frac_o
);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(success_o) && $stable(div_hi_o)
                              && $stable(div_lo_o) && $stable(frac_o)));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(baud_q_i)));

  // R7
  zero_baud_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && baud_i == '0) |=> (done_o && !success_o && div_hi_o == 8'h00
                                   && div_lo_o == 8'h00 && frac_o == 8'h10));

  // R6
  fallback_frac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !success_o) |-> (frac_o == 8'h10));

  // R2
  frac_mul_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && success_o) |-> (frac_o[7:4] != 4'd0));
endmodule

bind baud_frac_search baud_frac_search_chk #(.W(CLK_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .baud_i    (baud_i),
  .accept_i  (accept),
  .baud_q_i  (baud_q),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .success_o (success_o),
  .div_hi_o  (div_hi_o),
  .div_lo_o  (div_lo_o),
  .frac_o    (frac_o)
);

// File: tb/baud_frac_search_tb.sv
`timescale 1ns/1ps
module baud_frac_search_tb;
  localparam int CW   = 24;
  localparam int UNIT = CW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] uclk_in = '0;
  logic [CW-1:0] baud_in = '0;
  logic          busy, done, ok;
  logic [7:0]    hi, lo, fr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  baud_frac_search #(.CLK_W(CW)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .uart_clk_i (uclk_in),
    .baud_i     (baud_in),
    .busy_o     (busy),
    .done_o     (done),
    .success_o  (ok),
    .div_hi_o   (hi),
    .div_lo_o   (lo),
    .frac_o     (fr)
  );

  task automatic chk(input bit cond, input string what, input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // reference search written from the requirements
  task automatic model(input longint ck, input longint bd, output bit eok,
                       output longint ehi, output longint elo, output longint efr,
                       output int ncand);
    longint pc, best, bm, ba, bdv, t, d, c, e, fb;
    bit hit;
    pc = ck / 16; best = 100000; bm = 1; ba = 0; bdv = 0; hit = 0; ncand = 0;
    if (bd == 0) begin
      eok = 0; ehi = 0; elo = 0; efr = 16; return;
    end
    for (int m = 1; m <= 15 && !hit; m++) begin
      for (int a = 0; a <= 15 && !hit; a++) begin
        ncand++;
        t = (m * pc) / (m + a);
        d = t / bd;
        if ((t % bd) * 2 > bd - (bd % 2)) d++;
        if (d >= 3 && d <= 65535) begin
          c = t / d;
          e = (c >= bd) ? c - bd : bd - c;
          if (e < best) begin
            best = e; bm = m; ba = a; bdv = d;
            if (e == 0) hit = 1;
          end
        end
      end
    end
    eok = best < bd / 30;
    if (eok) begin
      ehi = (bdv / 256) % 256; elo = bdv % 256; efr = bm * 16 + ba;
    end else begin
      fb = pc / bd;
      ehi = (fb / 256) % 256; elo = fb % 256; efr = 16;
    end
  endtask

  // drive start for one cycle, return cycles from the accepting edge to done
  task automatic launch_and_wait(input longint ck, input longint bd, output int k,
                                 output bit busy_seen);
    @(negedge clk);
    start = 1'b1; uclk_in = CW'(ck); baud_in = CW'(bd);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    k = 0;
    while (!done && k < 40000) begin
      k++;
      @(negedge clk);
    end
  endtask

  task automatic check_result(input string tag, input longint ck, input longint bd);
    bit eok, bs; longint ehi, elo, efr, ek; int n, k;
    model(ck, bd, eok, ehi, elo, efr, n);
    launch_and_wait(ck, bd, k, bs);
    ek = (bd == 0) ? 0 : (eok ? (3*n + 1) * UNIT : (3*n + 2) * UNIT);
    $display("%s: clk %0d baud %0d -> ok %0d hi %0d lo %0d frac %02h after %0d cycles",
             tag, ck, bd, ok, hi, lo, fr, k);
    chk(ok == eok, {tag, " R5 success flag"}, ok, eok);
    chk(hi == ehi, {tag, " R2/R6 divisor high byte"}, hi, ehi);
    chk(lo == elo, {tag, " R2/R6 divisor low byte"}, lo, elo);
    chk(fr == efr, {tag, " R2/R6 fractional byte"}, fr, efr);
    chk(k == ek, {tag, " R4 cycles to done (R3 stop point)"}, k, ek);
    chk(busy == 1'b0, {tag, " R10 busy low with done"}, busy, 0);
    if (bd != 0) chk(bs == 1'b1, {tag, " R10 busy after accept"}, bs, 1);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && ok == 0, "R1 flags low after reset",
        {busy, done, ok}, 0);
    chk(hi == 0 && lo == 0 && fr == 0, "R1 result bytes zero after reset",
        {hi, lo, fr}, 0);
  endtask

  task automatic t_exact();
    // exact rate at the very first pair: R3 early stop, one candidate
    check_result("R3 exact 16M/10000", 64'd16000000, 64'd10000);
    chk(fr == 8'h10 && lo == 8'd100, "R3 first pair stored", {hi, lo, fr}, 24'h006410);
    check_result("R3 exact 14.7456M/115200", 64'd14745600, 64'd115200);
  endtask

  task automatic t_generic();
    check_result("R2 12M/115200", 64'd12000000, 64'd115200);
    check_result("R2 12M/9600", 64'd12000000, 64'd9600);
  endtask

  task automatic t_fail();
    check_result("R6 16M/400000", 64'd16000000, 64'd400000);
    chk(ok == 0 && lo == 8'd2 && fr == 8'h10, "R6 fallback 2 with 0x10",
        {ok, lo, fr}, {1'b0, 8'd2, 8'h10});
  endtask

  task automatic t_zero();
    check_result("R7 zero baud", 64'd12000000, 64'd0);
    chk(done == 1 && ok == 0 && fr == 8'h10, "R7 zero baud immediate failure",
        {done, ok, fr}, {1'b1, 1'b0, 8'h10});
  endtask

  task automatic t_hold();
    logic [7:0] h0, l0, f0; bit o0;
    h0 = hi; l0 = lo; f0 = fr; o0 = ok;
    @(negedge clk);
    uclk_in = 24'd777777; baud_in = 24'd1234;
    repeat (40) @(negedge clk);
    chk(done == 1, "R9 done held", done, 1);
    chk({ok, hi, lo, fr} == {o0, h0, l0, f0}, "R9 results held",
        {ok, hi, lo, fr}, {o0, h0, l0, f0});
  endtask

  task automatic t_busy_start();
    bit eok; longint ehi, elo, efr, ek; int n, k;
    model(64'd1000, 64'd9600, eok, ehi, elo, efr, n);
    ek = (3*n + 2) * UNIT;
    @(negedge clk);
    start = 1'b1; uclk_in = 24'd1000; baud_in = 24'd9600;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 40000) begin
      k++;
      if (k == 100) begin start = 1'b1; uclk_in = 24'd16000000; baud_in = 24'd10000; end
      if (k == 101) start = 1'b0;
      @(negedge clk);
    end
    chk(k == ek, "R8 run length unchanged by start while busy", k, ek);
    chk(ok == eok && lo == elo && hi == ehi && fr == efr,
        "R8 results from first inputs", {ok, hi, lo, fr}, {eok, 8'(ehi), 8'(elo), 8'(efr)});
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_exact();
    t_generic();
    t_hold();
    t_fail();
    t_zero();
    t_hold();
    t_busy_start();
    repeat (5) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule